// File: doc/BRIEF.md
# Pipelined Sorted-Table Key Locator

This block finds where a 4-bit key sits in a table of eight ascending 4-bit unsigned values. The table lives in eight registers that are loaded through a simple write port. Each lookup narrows a lower and an upper bound by one halving step per stage. It starts from a lower bound of 0 and an upper bound of 8, so the upper bound is one bit wider than an index.

The search is unrolled into four identical registered stages. A new key may be presented on every clock. Up to four lookups are in flight at once, one in each stage, and one result leaves the pipe per cycle. A key that matches early still travels through every remaining stage unchanged. The result is the final lower bound. Keys are assumed to be present in the table; for an absent key the index is unspecified.

Top module: `bsrch_pipe`

## Requirements
- R1: After a clock edge with `rst` high, `out_valid` is 0, and it remains 0 until a key accepted after reset reaches the end of the pipe.
- R2: `out_valid` equals the value `in_valid` had exactly four clock edges earlier, counted from the edge that accepts the key.
- R3: When `out_valid` is 1, `out_index` is the position (0 = first entry) whose stored value equals the key accepted four edges earlier. This holds provided the table is ascending, the key is in it, and no write happened during that lookup.
- R4: Keys presented on consecutive cycles each produce a correct result on consecutive cycles, with no stall and no gap.
- R5: When `wr_en` is 1 at a clock edge, the entry at `wr_addr` takes the value `wr_data`, and lookups accepted afterwards see the new value.
- R6: When `wr_en` is 0 at a clock edge, no table entry changes, whatever `wr_addr` and `wr_data` hold.
- R7: Keys stored at the extreme positions 0 and 7, which need the full depth of bisection, return indices 0 and 7.
- R8: A cycle with `in_valid` low between valid keys yields a cycle with `out_valid` low at the matching output slot, and the neighbouring results remain correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the stage valid flags |
| in_valid | input | 1 | A key is presented this cycle |
| in_key | input | 4 | Key to locate |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 3 | Table entry to write |
| wr_data | input | 4 | Value to store |
| out_valid | output | 1 | `out_index` carries a result |
| out_index | output | 3 | Position of the matching entry |

## Verification
The hardest case to reach from the ports is a pipe filled in every stage while the table changes. A write that lands under a lookup already in flight would leave that result undefined. The stimulus therefore separates writes from searches with idle cycles. Writes that keep the table ascending are followed by lookups of the new value, so that any stage still reading a stale or wrong entry returns a wrong index. Back-to-back key streams and streams with bubbles then exercise full occupancy, with expectations computed from a linear scan of the bench's own copy of the table.

// File: rtl/bsrch_pkg.sv
`timescale 1ns/1ps
package bsrch_pkg;
  typedef enum logic [1:0] {
    CMP_BELOW = 2'd0,
    CMP_MATCH = 2'd1,
    CMP_ABOVE = 2'd2
  } cmp_e;

  function automatic cmp_e compare_key(input logic [7:0] key, input logic [7:0] ent);
    if (key == ent)     return CMP_MATCH;
    else if (key > ent) return CMP_ABOVE;
    else                return CMP_BELOW;
  endfunction
endpackage

// File: rtl/bsrch_table.sv
`timescale 1ns/1ps
module bsrch_table #(
  parameter int KEY_W = 4,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_addr,
  input  logic [KEY_W-1:0]       wr_data,
  output logic [DEPTH*KEY_W-1:0] entries
);
  logic [KEY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign entries[g*KEY_W +: KEY_W] = mem[g];
  end
endmodule

// File: rtl/bsrch_stage.sv
`timescale 1ns/1ps
module bsrch_stage #(
  parameter int KEY_W = 4,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BND_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEPTH*KEY_W-1:0] entries,
  input  logic                   in_vld,
  input  logic [KEY_W-1:0]       in_key,
  input  logic [BND_W-1:0]       in_lo,
  input  logic [BND_W-1:0]       in_hi,
  output logic                   out_vld,
  output logic [KEY_W-1:0]       out_key,
  output logic [BND_W-1:0]       out_lo,
  output logic [BND_W-1:0]       out_hi
);
  import bsrch_pkg::*;

  logic [BND_W:0]     sum;
  logic [IDX_W-1:0]   probe;
  logic [KEY_W-1:0]   ent;
  logic [BND_W-1:0]   probe_b;
  cmp_e               cmp;
  logic [1:0]         unused_sum;

  // halving by taking the upper bits of the sum; probe wraps modulo DEPTH
  assign sum        = {1'b0, in_lo} + {1'b0, in_hi};
  assign probe      = sum[IDX_W:1];
  assign unused_sum = {sum[BND_W], sum[0]};
  assign probe_b    = {1'b0, probe};
  assign ent        = entries[probe*KEY_W +: KEY_W];
  assign cmp        = compare_key(8'(in_key), 8'(ent));

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
    out_key <= in_key;
    unique case (cmp)
      CMP_MATCH: begin out_lo <= probe_b; out_hi <= probe_b; end
      CMP_ABOVE: begin out_lo <= probe_b; out_hi <= in_hi;   end
      default:   begin out_lo <= in_lo;   out_hi <= probe_b; end
    endcase
  end
endmodule

// File: rtl/bsrch_pipe.sv
`timescale 1ns/1ps
module bsrch_pipe #(
  parameter int KEY_W  = 4,
  parameter int DEPTH  = 8,
  parameter int STAGES = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BND_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index
);
  logic [DEPTH*KEY_W-1:0] tbl_flat;
  logic                   vld [STAGES+1];
  logic [KEY_W-1:0]       key [STAGES+1];
  logic [BND_W-1:0]       lo  [STAGES+1];
  logic [BND_W-1:0]       hi  [STAGES+1];
  logic [KEY_W+BND_W:0]   unused_tail;

  bsrch_table #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .entries(tbl_flat)
  );

  assign vld[0] = in_valid;
  assign key[0] = in_key;
  assign lo[0]  = '0;
  assign hi[0]  = BND_W'(DEPTH);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bsrch_stage #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_stage (
      .clk(clk), .rst(rst), .entries(tbl_flat),
      .in_vld(vld[s]), .in_key(key[s]), .in_lo(lo[s]), .in_hi(hi[s]),
      .out_vld(vld[s+1]), .out_key(key[s+1]), .out_lo(lo[s+1]), .out_hi(hi[s+1])
    );
  end

  assign out_valid   = vld[STAGES];
  assign out_index   = lo[STAGES][IDX_W-1:0];
  assign unused_tail = {key[STAGES], hi[STAGES], lo[STAGES][BND_W-1]};
endmodule

// File: rtl/bsrch_pipe_chk.sv
`timescale 1ns/1ps
module bsrch_pipe_chk #(
  parameter int KEY_W  = 4,
  parameter int DEPTH  = 8,
  parameter int STAGES = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [KEY_W-1:0]       in_key,
  input logic                   wr_en,
  input logic [IDX_W-1:0]       wr_addr,
  input logic [KEY_W-1:0]       wr_data,
  input logic                   out_valid,
  input logic [IDX_W-1:0]       out_index,
  input logic [DEPTH*KEY_W-1:0] tbl_flat
);
  logic             vld_dly [STAGES];
  logic [KEY_W-1:0] key_dly [STAGES];
  int unsigned      quiet = 0;

  always_ff @(posedge clk) begin
    for (int i = STAGES-1; i > 0; i--) begin
      vld_dly[i] <= rst ? 1'b0 : vld_dly[i-1];
      key_dly[i] <= key_dly[i-1];
    end
    vld_dly[0] <= rst ? 1'b0 : in_valid;
    key_dly[0] <= in_key;
    if (wr_en) quiet <= 0;
    else if (quiet < STAGES) quiet <= quiet + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == vld_dly[STAGES-1]);

  assert_index_hits_key_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && vld_dly[STAGES-1] && quiet >= STAGES)
      |-> tbl_flat[out_index*KEY_W +: KEY_W] == key_dly[STAGES-1]);

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> tbl_flat[$past(wr_addr)*KEY_W +: KEY_W] == $past(wr_data));

  assert_no_write_no_change_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$isunknown($past(tbl_flat))) |-> $stable(tbl_flat));
endmodule

bind bsrch_pipe bsrch_pipe_chk #(.KEY_W(KEY_W), .DEPTH(DEPTH), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .out_valid(out_valid), .out_index(out_index), .tbl_flat(tbl_flat)
);

// File: tb/test_bsrch_pipe.sv
`timescale 1ns/1ps
module test_bsrch_pipe;
  localparam int KEY_W = 4, DEPTH = 8, STAGES = 4, IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [KEY_W-1:0] in_key = '0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [KEY_W-1:0] wr_data = '0;
  logic out_valid;
  logic [IDX_W-1:0] out_index;

  int n_checks = 0;
  int n_fail = 0;

  logic [KEY_W-1:0] model [DEPTH];
  logic             exp_v [STAGES];
  logic [IDX_W-1:0] exp_i [STAGES];
  string            exp_t [STAGES];

  always #4 clk = ~clk;

  bsrch_pipe #(.KEY_W(KEY_W), .DEPTH(DEPTH), .STAGES(STAGES)) i_bsrch_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_index(out_index)
  );

  function automatic logic [IDX_W-1:0] locate(input logic [KEY_W-1:0] k);
    for (int i = 0; i < DEPTH; i++) if (model[i] == k) return IDX_W'(i);
    return '0;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // one cycle: compare output with the expectation from four steps back, then drive
  task automatic step(input bit v, input logic [KEY_W-1:0] k, input string tag);
    @(negedge clk);
    if (exp_v[STAGES-1]) begin
      check(exp_t[STAGES-1], out_valid === 1'b1, int'(out_valid), 1);
      check(exp_t[STAGES-1], out_index === exp_i[STAGES-1], int'(out_index), int'(exp_i[STAGES-1]));
    end else begin
      check({exp_t[STAGES-1], " idle slot"}, out_valid === 1'b0, int'(out_valid), 0);
    end
    for (int i = STAGES-1; i > 0; i--) begin
      exp_v[i] = exp_v[i-1]; exp_i[i] = exp_i[i-1]; exp_t[i] = exp_t[i-1];
    end
    exp_v[0] = v; exp_i[0] = locate(k); exp_t[0] = v ? tag : "R8";
    in_valid = v; in_key = k; wr_en = 1'b0;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < STAGES + 1; i++) step(1'b0, '0, tag);
  endtask

  task automatic write_entry(input bit en, input logic [IDX_W-1:0] a, input logic [KEY_W-1:0] d);
    step(1'b0, '0, "R6");
    wr_en = en; wr_addr = a; wr_data = d;
    if (en) model[a] = d;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < STAGES; i++) begin exp_v[i] = 1'b0; exp_i[i] = '0; exp_t[i] = "R1"; end
    repeat (3) @(negedge clk);
    check("R1 out_valid under reset", out_valid === 1'b0, int'(out_valid), 0);
    rst = 1'b0;
    flush("R1");
  endtask

  task automatic t_load();
    logic [KEY_W-1:0] vals [DEPTH] = '{4'd1, 4'd3, 4'd4, 4'd6, 4'd9, 4'd10, 4'd12, 4'd14};
    for (int i = 0; i < DEPTH; i++) write_entry(1'b1, IDX_W'(i), vals[i]);
    flush("R5");
  endtask

  task automatic t_single();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, model[i], "R3");
      flush("R3");
    end
  endtask

  task automatic t_stream();
    for (int i = DEPTH-1; i >= 0; i--) step(1'b1, model[i], "R4");
    for (int i = 0; i < DEPTH; i++) step(1'b1, model[(i*3) % DEPTH], "R4");
    flush("R4");
  endtask

  task automatic t_edges();
    step(1'b1, model[0], "R7");
    step(1'b1, model[DEPTH-1], "R7");
    step(1'b1, model[0], "R7");
    flush("R7");
  endtask

  task automatic t_bubbles();
    step(1'b1, model[2], "R8");
    step(1'b0, '0, "R8");
    step(1'b1, model[5], "R8");
    step(1'b0, '0, "R8");
    step(1'b0, '0, "R8");
    step(1'b1, model[7], "R8");
    flush("R8");
  endtask

  task automatic t_write_update();
    write_entry(1'b1, 3'd7, 4'd15);
    write_entry(1'b1, 3'd0, 4'd0);
    flush("R5");
    step(1'b1, 4'd15, "R5");
    step(1'b1, 4'd0, "R5");
    flush("R5");
  endtask

  task automatic t_write_disabled();
    // strobe low with a value that would break lookups of entries 3 and 5
    step(1'b0, '0, "R6");
    wr_en = 1'b0; wr_addr = 3'd3; wr_data = 4'd11;
    step(1'b0, '0, "R6");
    wr_en = 1'b0; wr_addr = 3'd5; wr_data = 4'd2;
    flush("R6");
    step(1'b1, model[3], "R6");
    step(1'b1, model[5], "R6");
    flush("R6");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_single();
    t_stream();
    t_edges();
    t_bubbles();
    t_write_update();
    t_write_disabled();
    t_reset();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule